// File: doc/BRIEF.md
# Token-Chained Acquisition Bus Sender

This block sits on one acquisition card in a rack where several cards share a 32-bit synchronous output bus. A trigger pulse starts a programmable delay counted in fixed time steps. When the delay runs out, the block issues a one-cycle start strobe to the converters. The converters return one flat vector of 16-bit channel results together with a valid pulse, and the block captures that set at once. The card then waits for its turn. Turns are handed from card to card as an active-low token pulse. When the card has the token, it drives its words onto the bus and then passes a one-cycle active-low token pulse to the next card.

A card whose slot ID is nonzero acts as master. Before its channel words it sends one header word, copied from a header register input. A card with a zero slot ID sends only its channel words. Each bus word carries two channels, with the lower-numbered channel in bits 15:0. A trigger that arrives before the previous set has left the card is discarded and raises a sticky overrun flag.

Back-pressure rules. The outgoing bus is valid/ready. A word counts as delivered on a clock edge where `bus_valid` and `bus_ready` are both high. While `bus_valid` is high and `bus_ready` is low, the word and `bus_valid` stay unchanged. The converter side has no ready, because a converter cannot be held off. An `adc_valid` pulse is taken only while the block is waiting for a conversion result. At all other times it is ignored.

Top module: `acq_bus_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `bus_valid` is 0, `conv_start` is 0, `overrun` is 0 and `tok_out_n` is 1.
- R2: A `conv_trig` sampled while idle makes `conv_start` high for exactly one cycle. It goes high on the (D*STEP_CYC+1)-th rising edge after the edge that sampled the trigger, where D is the value of `conv_dly`.
- R3: The channel set on `adc_data` is captured on the first `adc_valid` after the start strobe. An `adc_valid` during the delay, or after capture, has no effect on the words sent. Channel c occupies `adc_data[16c+15:16c]`.
- R4: After capture, `bus_valid` stays low until a token has been seen as `tok_in_n` sampled low.
- R5: With a nonzero `slot_id`, the first word sent equals `hdr_word`, followed by the channel words, for NCH/2+1 words in total.
- R6: With `slot_id` equal to 0, no header is sent and exactly NCH/2 words leave the card.
- R7: Channel word w (counting from 0) is {channel 2w+1, channel 2w}, so the lower-numbered channel is in bits 15:0.
- R8: While `bus_valid` is high and `bus_ready` is low, the next cycle still has `bus_valid` high and the same `bus_data`.
- R9: `tok_out_n` goes low for exactly one cycle, in the cycle after the edge that delivers the last word. `bus_valid` is low in that cycle.
- R10: A `conv_trig` that arrives while a set is still pending produces no `conv_start` and no extra words, and sets `overrun`. `overrun` then stays set until reset. A normal trigger never sets it.
- R11: A token pulse that arrives while the card is idle, before its data is ready, is remembered. The set is then sent as soon as it has been captured, with no second token needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_trig | input | 1 | Conversion request pulse |
| conv_dly | input | DLY_W | Delay before the converter strobe, in steps of STEP_CYC cycles |
| conv_start | output | 1 | One-cycle converter start strobe |
| adc_valid | input | 1 | Converter results present on adc_data |
| adc_data | input | NCH*DW | Channel results, channel c at bits 16c+15:16c |
| slot_id | input | SLOT_W | Slot position; nonzero makes the card master |
| hdr_word | input | 2*DW | Header value sent by a master |
| tok_in_n | input | 1 | Active-low token from the previous card |
| tok_out_n | output | 1 | Active-low one-cycle token to the next card |
| bus_data | output | 2*DW | Bus word |
| bus_valid | output | 1 | Bus word valid |
| bus_ready | input | 1 | Bus accepts the word at this edge |
| overrun | output | 1 | Sticky flag: a trigger was dropped |

## Verification
A wrong phase or word counter shows up at the bus within one word time. It appears as a header where none belongs, a missing or repeated channel pair, or a token pulse that comes too early, too late or lasts two cycles. A delay counter that is off by one moves `conv_start` by one cycle, and the exact edge count catches this. A capture enable that is open at the wrong time replaces the expected channel words with the junk vector the bench drives outside the conversion window. A busy check that fails lets a second strobe or a second burst appear, and the strobe count and the overrun flag detect it within the same set.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DELAY,
    PH_CONV,
    PH_READY,
    PH_SEND
  } phase_t;
endpackage

// File: rtl/acq_conv_delay.sv
`timescale 1ns/1ps
// Counts conv_dly steps of STEP_CYC cycles, then emits a one-cycle strobe.
module acq_conv_delay #(
  parameter int DLY_W    = 24,
  parameter int STEP_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [DLY_W-1:0] dly,
  output logic             strobe
);
  localparam int TOT_W = DLY_W + $clog2(STEP_CYC + 1);

  logic [TOT_W-1:0] remain;
  logic             running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      running <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (arm) begin
        remain  <= TOT_W'(dly) * TOT_W'(STEP_CYC);
        running <= 1'b1;
      end else if (running) begin
        if (remain == '0) begin
          strobe  <= 1'b1;
          running <= 1'b0;
        end else begin
          remain <= remain - TOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/acq_sample_reg.sv
`timescale 1ns/1ps
// Holds one complete channel set until it has been sent.
module acq_sample_reg #(
  parameter int NCH = 16,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCH*DW-1:0] din,
  output logic [NCH*DW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/acq_bus_tx.sv
`timescale 1ns/1ps
// Walks optional header plus channel pairs onto the valid/ready bus,
// then emits the outgoing token pulse.
module acq_bus_tx #(
  parameter int NCH = 16,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              master,
  input  logic [2*DW-1:0]   hdr,
  input  logic [NCH*DW-1:0] samples,
  input  logic              bus_ready,
  output logic              bus_valid,
  output logic [2*DW-1:0]   bus_data,
  output logic              tok_out_n,
  output logic              done
);
  localparam int NW = NCH / 2;
  localparam int IW = $clog2(NW + 2);
  localparam int WW = $clog2(NW);

  logic [2*DW-1:0] words [NW];
  logic [2*DW-1:0] hdr_q;
  logic            m_q;
  logic            active;
  logic            tok_pulse;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   rel;
  logic            last;

  for (genvar g = 0; g < NW; g++) begin : g_pair
    assign words[g] = samples[g*2*DW +: 2*DW];
  end

  assign rel  = idx - IW'(m_q);
  assign last = (idx == IW'(NW - 1) + IW'(m_q));
  assign done = active && bus_ready && last;

  always_comb begin
    if (m_q && idx == '0) bus_data = hdr_q;
    else                  bus_data = words[WW'(rel)];
  end

  assign bus_valid = active;
  assign tok_out_n = ~tok_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      tok_pulse <= 1'b0;
      idx       <= '0;
      m_q       <= 1'b0;
      hdr_q     <= '0;
    end else begin
      tok_pulse <= 1'b0;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
        m_q    <= master;
        hdr_q  <= hdr;
      end else if (active && bus_ready) begin
        if (last) begin
          active    <= 1'b0;
          tok_pulse <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/acq_bus_ctrl.sv
`timescale 1ns/1ps
module acq_bus_ctrl
  import acq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int DW       = 16,
  parameter int SLOT_W   = 4,
  parameter int DLY_W    = 24,
  parameter int STEP_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_trig,
  input  logic [DLY_W-1:0]  conv_dly,
  output logic              conv_start,
  input  logic              adc_valid,
  input  logic [NCH*DW-1:0] adc_data,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic [2*DW-1:0]   hdr_word,
  input  logic              tok_in_n,
  output logic              tok_out_n,
  output logic [2*DW-1:0]   bus_data,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              overrun
);
  phase_t            phase;
  logic              tok_held;
  logic              arm, load, go, tx_done;
  logic [NCH*DW-1:0] held_set;

  assign arm  = conv_trig && (phase == PH_IDLE);
  assign load = adc_valid && (phase == PH_CONV);
  assign go   = (phase == PH_READY) && (tok_held || !tok_in_n);

  acq_conv_delay #(.DLY_W(DLY_W), .STEP_CYC(STEP_CYC)) u_dly (
    .clk(clk), .rst_n(rst_n), .arm(arm), .dly(conv_dly), .strobe(conv_start)
  );

  acq_sample_reg #(.NCH(NCH), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .load(load), .din(adc_data), .dout(held_set)
  );

  acq_bus_tx #(.NCH(NCH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .master(slot_id != '0),
    .hdr(hdr_word), .samples(held_set), .bus_ready(bus_ready),
    .bus_valid(bus_valid), .bus_data(bus_data), .tok_out_n(tok_out_n),
    .done(tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      tok_held <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (go)             tok_held <= 1'b0;
      else if (!tok_in_n) tok_held <= 1'b1;

      if (conv_trig && phase != PH_IDLE) overrun <= 1'b1;

      unique case (phase)
        PH_IDLE:  if (arm)        phase <= PH_DELAY;
        PH_DELAY: if (conv_start) phase <= PH_CONV;
        PH_CONV:  if (load)       phase <= PH_READY;
        PH_READY: if (go)         phase <= PH_SEND;
        PH_SEND:  if (tx_done)    phase <= PH_IDLE;
        default:                  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acq_bus_ctrl_chk.sv
`timescale 1ns/1ps
module acq_bus_ctrl_chk #(
  parameter int BW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_trig,
  input logic          conv_start,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [BW-1:0] bus_data,
  input logic          tok_out_n,
  input logic          overrun
);
  assert_conv_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data));

  assert_tok_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_out_n |=> tok_out_n);

  assert_tok_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tok_out_n) |-> $past(bus_valid && bus_ready) && !bus_valid);

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(conv_trig));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind acq_bus_ctrl acq_bus_ctrl_chk #(.BW(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_trig(conv_trig), .conv_start(conv_start),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_data(bus_data),
  .tok_out_n(tok_out_n), .overrun(overrun)
);

// File: tb/sim_acq_bus_ctrl.sv
`timescale 1ns/1ps
module sim_acq_bus_ctrl;
  localparam int NCH = 16, DW = 16, SLOT_W = 4, DLY_W = 8, STEP = 4;
  localparam int NW = NCH / 2;

  logic              clk, rst_n, conv_trig, conv_start, adc_valid;
  logic [DLY_W-1:0]  conv_dly;
  logic [NCH*DW-1:0] adc_data;
  logic [SLOT_W-1:0] slot_id;
  logic [2*DW-1:0]   hdr_word, bus_data;
  logic              tok_in_n, tok_out_n, bus_valid, bus_ready, overrun;

  acq_bus_ctrl #(.NCH(NCH), .DW(DW), .SLOT_W(SLOT_W), .DLY_W(DLY_W),
                 .STEP_CYC(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_trig(conv_trig), .conv_dly(conv_dly),
    .conv_start(conv_start), .adc_valid(adc_valid), .adc_data(adc_data),
    .slot_id(slot_id), .hdr_word(hdr_word), .tok_in_n(tok_in_n),
    .tok_out_n(tok_out_n), .bus_data(bus_data), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0, errs = 0, cs_count = 0, cyc = 0;
  bit ovr_exp = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (conv_start) cs_count++;
    if (cyc == 150000) begin
      errs++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int i, bit m, logic [31:0] h,
                                           logic [NCH*DW-1:0] d);
    int w;
    if (m && i == 0) return h;
    w = i - int'(m);
    return d[w*32 +: 32];
  endfunction

  task automatic run_set(bit m, int d, bit early, int bp, bit ovr);
    logic [NCH*DW-1:0] smp;
    logic [31:0] h, hold;
    int n, idx, total, cs0, guard;
    bit pend, r;
    for (int c = 0; c < NCH; c++) smp[c*DW +: DW] = DW'($urandom);
    h        = $urandom;
    slot_id  = m ? SLOT_W'($urandom_range(1, 15)) : '0;
    hdr_word = h;
    conv_dly = DLY_W'(d);
    cs0      = cs_count;
    if (early) begin
      @(negedge clk) tok_in_n = 1'b0;
      @(negedge clk) tok_in_n = 1'b1;
    end
    @(negedge clk) conv_trig = 1'b1;
    @(negedge clk) conv_trig = 1'b0;
    adc_valid = 1'b1;            // junk during delay must be ignored (R3)
    adc_data  = ~smp;
    chk(conv_start == 1'b0, "R2 strobe early", conv_start, 0);
    n = 0;
    do begin
      @(negedge clk);
      adc_valid = 1'b0;
      n++;
    end while (!conv_start && n < 2000);
    chk(n == d*STEP + 1, "R2 strobe edge count", n, d*STEP + 1);
    if (ovr) begin
      @(negedge clk) conv_trig = 1'b1;
      @(negedge clk) conv_trig = 1'b0;
      ovr_exp = 1'b1;
      chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    end
    repeat ($urandom_range(1, 3)) @(negedge clk);
    adc_data  = smp;
    adc_valid = 1'b1;
    @(negedge clk);
    adc_data  = ~smp;            // junk after capture must be ignored (R3)
    @(negedge clk);
    adc_valid = 1'b0;
    if (!early) begin
      repeat (4) begin
        chk(bus_valid == 1'b0, "R4 quiet before token", bus_valid, 0);
        @(negedge clk);
      end
      tok_in_n = 1'b0;
      @(negedge clk);
      tok_in_n = 1'b1;
    end
    total = NW + int'(m);
    idx = 0; guard = 0; pend = 1'b0; hold = '0;
    while (idx < total && guard < 600) begin
      chk(tok_out_n == 1'b1, "R9 token during burst", tok_out_n, 1);
      if (bus_valid) begin
        if (pend) chk(bus_data == hold, "R8 held word", bus_data, hold);
        r = ($urandom_range(0, 99) >= bp);
        bus_ready = r;
        if (r) begin
          chk(bus_data == exp_word(idx, m, h, smp),
              (m && idx == 0) ? "R5 header" : (m ? "R7 pair" : "R6 R7 pair"),
              bus_data, exp_word(idx, m, h, smp));
          idx++;
          pend = 1'b0;
        end else begin
          pend = 1'b1;
          hold = bus_data;
        end
      end else begin
        chk(!pend, "R8 valid dropped", 0, 1);
        bus_ready = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    bus_ready = 1'b0;
    chk(idx == total, early ? "R11 held token burst" : "R5 R6 word count", idx, total);
    chk(tok_out_n == 1'b0, "R9 token pulse", tok_out_n, 0);
    chk(bus_valid == 1'b0, "R6 no extra word", bus_valid, 0);
    @(negedge clk);
    chk(tok_out_n == 1'b1, "R9 token width", tok_out_n, 1);
    chk(bus_valid == 1'b0, "R10 no second burst", bus_valid, 0);
    chk(cs_count - cs0 == 1, "R10 one strobe per set", cs_count - cs0, 1);
    chk(overrun == ovr_exp, "R10 overrun flag", overrun, ovr_exp);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; conv_trig = 1'b0; conv_dly = '0; adc_valid = 1'b0;
    adc_data = '0; slot_id = '0; hdr_word = '0; tok_in_n = 1'b1;
    bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_valid == 1'b0 && conv_start == 1'b0, "R1 reset outputs",
        {bus_valid, conv_start}, 0);
    chk(tok_out_n == 1'b1 && overrun == 1'b0, "R1 reset token/flag",
        {tok_out_n, overrun}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_valid == 1'b0 && tok_out_n == 1'b1, "R1 after reset",
        {bus_valid, tok_out_n}, 1);
    run_set(1'b1, 0, 1'b1, 0, 1'b0);   // master, no delay, early token (R11)
    run_set(1'b0, 3, 1'b0, 60, 1'b0);  // non-master, heavy back-pressure
    run_set(1'b1, 1, 1'b0, 0, 1'b0);
    run_set(1'b0, 0, 1'b1, 30, 1'b0);
    for (int k = 0; k < 10; k++)
      run_set(1'($urandom_range(0, 1)), $urandom_range(0, 6),
              1'($urandom_range(0, 1)), $urandom_range(0, 70), 1'b0);
    run_set(1'b1, 2, 1'b0, 30, 1'b1);  // dropped trigger (R10)
    run_set(1'b0, 1, 1'b0, 20, 1'b0);  // flag stays set afterwards
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule